// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block sits beside an I2C master/slave controller and watches the two bus lines after synchronising them to the system clock. It also watches the SDA level that the local master wants on the line. It follows the position inside each frame (eight data bits, then one acknowledge bit). From that it keeps three sticky status flags: the local master lost arbitration, a start or stop condition appeared in the middle of a byte, and the first byte after a start was the all-zero broadcast address.

The flags drive a level interrupt request when interrupts are enabled. They drive a one-cycle pulse that tells the controller to drop back to slave mode. They also drive an inhibit line that forbids the controller from holding SCL low while a fault is pending. Software clears the two fault flags by strobing a status read. The broadcast flag is cleared only by a stop condition. Clearing the peripheral enable wipes all three flags. A separate speed-mode bit (0 = standard, 1 = fast) is written by software and survives a disable.

Top module: `i2c_busmon`

## Requirements
- R1: A start condition is SDA falling while SCL stays high. A stop condition is SDA rising while SCL stays high. Either condition seen while the frame position is not zero (that is, after the first data bit has been clocked and before the acknowledge bit has finished) sets `bus_err`. One at position zero does not set it.
- R2: When `is_master`=1 and `is_rx`=0, on an SCL rising edge during data bits 0..7: if `sda_release`=1 (line released) and the sampled SDA is 0, `arb_lost` sets. In the same cycle `force_slave` pulses high for exactly one clock.
- R3: No arbitration check is made while `is_rx`=1 (master receive), during either the data bits or the acknowledge bit. No check is made on the acknowledge bit of a transmitted byte either. A mismatch there leaves `arb_lost` at 0.
- R4: A one-cycle `sr_read` clears `arb_lost` and `bus_err`. If a set event lands in the same cycle as the read, the flag ends up at 1.
- R5: While `periph_en`=0, all three flags are 0 one cycle later and no flag can set.
- R6: `irq` is 1 exactly when `irq_en`=1 and at least one of `arb_lost` or `bus_err` is 1.
- R7: `scl_hold_inhibit` is 1 whenever `arb_lost` or `bus_err` is 1, and 0 otherwise.
- R8: `gen_call` sets when all of these hold: `is_master`=0, `gcall_en`=1, and the first byte after a start is 0x00. It becomes 1 at the falling SCL edge of the eighth bit. A stop condition clears it; `sr_read` does not.
- R9: `speed_fast` resets to 0. It loads `speed_wdata` on a cycle with `speed_we`=1 and otherwise keeps its value, whatever `periph_en` does.
- R10: Each bus line passes through a two-stage synchroniser. A flag changes on the third rising clock edge after the bus input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_release | input | 1 | 1 = local master leaves SDA released this bit |
| is_master | input | 1 | Controller currently acts as master |
| is_rx | input | 1 | Master is receiving the current byte |
| periph_en | input | 1 | Peripheral enable; 0 clears all flags |
| irq_en | input | 1 | Interrupt enable |
| gcall_en | input | 1 | Enable broadcast-address detection |
| sr_read | input | 1 | Status read strobe (clears fault flags) |
| speed_we | input | 1 | Write strobe for the speed bit |
| speed_wdata | input | 1 | Value written to the speed bit |
| arb_lost | output | 1 | Arbitration lost flag |
| bus_err | output | 1 | Misplaced start/stop flag |
| gen_call | output | 1 | Broadcast address seen flag |
| irq | output | 1 | Interrupt request |
| force_slave | output | 1 | One-cycle request to return to slave mode |
| scl_hold_inhibit | output | 1 | Controller must not stretch SCL |
| speed_fast | output | 1 | 0 = standard, 1 = fast mode |

## Verification
The bench aims at frame-position corner cases:
- A stop after the acknowledge must stay clean. A design that counted position badly would flag a bus error on every normal transfer.
- A start or stop three bits into a byte must raise one.

For arbitration:
- A receive-mode byte whose acknowledge is pulled low by another master must not raise the flag.
- Neither must the acknowledge of a transmitted byte. A design that compares on every bit would lose arbitration falsely there.

Timing and persistence:
- A status read is placed in the exact cycle a bus error lands. A design that let the read win would drop the event.
- The bench also checks that the broadcast flag survives a status read.
- It checks that the speed bit survives a disable.

// File: rtl/i2c_busmon_pkg.sv
package i2c_busmon_pkg;

    localparam int BITS_PER_BYTE = 8;
    localparam int SYNC_STAGES   = 2;
    localparam int POS_W         = $clog2(BITS_PER_BYTE + 1);

    // synchronised line levels
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lvl_t;

    // bus happenings derived from two consecutive samples
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    // set/clear requests going into the flag bank
    typedef struct packed {
        logic arb_set;
        logic berr_set;
        logic gcall_set;
        logic gcall_clr;
    } flag_req_t;

    typedef struct packed {
        logic arb;
        logic berr;
        logic gcall;
    } flags_t;

    function automatic logic pos_is_mid_frame(input logic [POS_W-1:0] pos);
        return pos != '0;
    endfunction

endpackage

// File: rtl/busmon_sync.sv
module busmon_sync
    import i2c_busmon_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_lvl_t raw,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_cur;
    logic              sda_cur;

    // idle bus is high on both lines, so reset every stage to 1
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], raw.scl};
            sda_chain <= {sda_chain[STAGES-2:0], raw.sda};
            scl_prev  <= scl_chain[STAGES-1];
            sda_prev  <= sda_chain[STAGES-1];
        end
    end

    assign scl_cur = scl_chain[STAGES-1];
    assign sda_cur = sda_chain[STAGES-1];

    always_comb begin
        evt.start    = scl_cur && scl_prev && sda_prev && !sda_cur;
        evt.stop     = scl_cur && scl_prev && !sda_prev && sda_cur;
        evt.scl_rise = scl_cur && !scl_prev;
        evt.scl_fall = !scl_cur && scl_prev;
        evt.sda      = sda_cur;
    end

endmodule

// File: rtl/busmon_framer.sv
module busmon_framer
    import i2c_busmon_pkg::*;
#(
    parameter int BITS = BITS_PER_BYTE,
    localparam int PW  = $clog2(BITS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    output logic [PW-1:0] pos,
    output logic          misplaced,
    output logic          addr_zero
);

    localparam logic [PW-1:0] ACK_POS  = PW'(BITS);
    localparam logic [PW-1:0] LAST_BIT = PW'(BITS - 1);

    logic            bit_clocked;  // SCL rose during the current bit
    logic            first_byte;   // current byte is the one right after a start
    logic [BITS-1:0] shreg;

    assign misplaced = (evt.start || evt.stop) && (pos != '0);
    assign addr_zero = evt.scl_fall && bit_clocked && first_byte &&
                       (pos == LAST_BIT) && (shreg == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos         <= '0;
            bit_clocked <= 1'b0;
            first_byte  <= 1'b0;
            shreg       <= '0;
        end else if (evt.start) begin
            pos         <= '0;
            bit_clocked <= 1'b0;
            first_byte  <= 1'b1;
        end else if (evt.stop) begin
            pos         <= '0;
            bit_clocked <= 1'b0;
            first_byte  <= 1'b0;
        end else begin
            if (evt.scl_rise) begin
                bit_clocked <= 1'b1;
                if (pos < ACK_POS)
                    shreg <= {shreg[BITS-2:0], evt.sda};
            end
            if (evt.scl_fall && bit_clocked) begin
                bit_clocked <= 1'b0;
                if (pos == ACK_POS) begin
                    pos        <= '0;
                    first_byte <= 1'b0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/busmon_flags.sv
module busmon_flags
    import i2c_busmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      rd_clear,
    input  flag_req_t req,
    output flags_t    flags,
    output logic      slave_pulse
);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            flags       <= '0;
            slave_pulse <= 1'b0;
        end else begin
            // a set arriving with the read wins
            flags.arb   <= req.arb_set  || (flags.arb  && !rd_clear);
            flags.berr  <= req.berr_set || (flags.berr && !rd_clear);
            flags.gcall <= req.gcall_set || (flags.gcall && !req.gcall_clr);
            slave_pulse <= req.arb_set;
        end
    end

endmodule

// File: rtl/i2c_busmon.sv
module i2c_busmon
    import i2c_busmon_pkg::*;
#(
    parameter int BITS   = BITS_PER_BYTE,
    parameter int STAGES = SYNC_STAGES,
    localparam int PW    = $clog2(BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_release,
    input  logic is_master,
    input  logic is_rx,
    input  logic periph_en,
    input  logic irq_en,
    input  logic gcall_en,
    input  logic sr_read,
    input  logic speed_we,
    input  logic speed_wdata,
    output logic arb_lost,
    output logic bus_err,
    output logic gen_call,
    output logic irq,
    output logic force_slave,
    output logic scl_hold_inhibit,
    output logic speed_fast
);

    localparam logic [PW-1:0] ACK_POS = PW'(BITS);

    bus_lvl_t      raw;
    bus_evt_t      evt;
    logic [PW-1:0] pos;
    logic          misplaced;
    logic          addr_zero;
    flag_req_t     req;
    flags_t        flags;

    assign raw.scl = scl_in;
    assign raw.sda = sda_in;

    busmon_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (raw),
        .evt (evt)
    );

    busmon_framer #(.BITS(BITS)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .pos       (pos),
        .misplaced (misplaced),
        .addr_zero (addr_zero)
    );

    // compare only on bits the local master itself drives: data bits of a
    // transmitted byte; receive bytes and every acknowledge are skipped
    always_comb begin
        req.arb_set   = is_master && !is_rx && evt.scl_rise && (pos < ACK_POS) &&
                        sda_release && !evt.sda;
        req.berr_set  = misplaced;
        req.gcall_set = !is_master && gcall_en && addr_zero;
        req.gcall_clr = evt.stop;
    end

    busmon_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .enable      (periph_en),
        .rd_clear    (sr_read),
        .req         (req),
        .flags       (flags),
        .slave_pulse (force_slave)
    );

    always_ff @(posedge clk) begin
        if (rst)
            speed_fast <= 1'b0;
        else if (speed_we)
            speed_fast <= speed_wdata;
    end

    assign arb_lost         = flags.arb;
    assign bus_err          = flags.berr;
    assign gen_call         = flags.gcall;
    assign scl_hold_inhibit = flags.arb || flags.berr;
    assign irq              = irq_en && scl_hold_inhibit;

endmodule

// File: rtl/i2c_busmon_chk.sv
module i2c_busmon_chk (
    input logic clk,
    input logic rst,
    input logic periph_en,
    input logic irq_en,
    input logic is_master,
    input logic is_rx,
    input logic speed_we,
    input logic arb_lost,
    input logic bus_err,
    input logic gen_call,
    input logic irq,
    input logic force_slave,
    input logic scl_hold_inhibit,
    input logic speed_fast
);

    // R5
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !periph_en |=> (!arb_lost && !bus_err && !gen_call));

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en && (bus_err || arb_lost)) |-> irq);

    // R7
    hold_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_lost || bus_err) |-> scl_hold_inhibit);

    // R2
    slave_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_lost) |-> force_slave);

    // R2
    slave_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        force_slave |=> !force_slave);

    // R3
    rx_noarb_chk: assert property (@(posedge clk) disable iff (rst)
        (is_master && is_rx && !arb_lost) |=> !arb_lost);

    // R9
    speed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !speed_we |=> $stable(speed_fast));

endmodule

bind i2c_busmon i2c_busmon_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .periph_en        (periph_en),
    .irq_en           (irq_en),
    .is_master        (is_master),
    .is_rx            (is_rx),
    .speed_we         (speed_we),
    .arb_lost         (arb_lost),
    .bus_err          (bus_err),
    .gen_call         (gen_call),
    .irq              (irq),
    .force_slave      (force_slave),
    .scl_hold_inhibit (scl_hold_inhibit),
    .speed_fast       (speed_fast)
);

// File: tb/i2c_busmon_test.sv
`timescale 1ns/1ps
module i2c_busmon_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_release = 1'b1;
    logic is_master = 1'b0, is_rx = 1'b0, periph_en = 1'b0, irq_en = 1'b0;
    logic gcall_en = 1'b0, sr_read = 1'b0, speed_we = 1'b0, speed_wdata = 1'b0;
    logic arb_lost, bus_err, gen_call, irq, force_slave, scl_hold_inhibit, speed_fast;

    always #2.5 clk = ~clk;

    i2c_busmon uut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_release(sda_release), .is_master(is_master), .is_rx(is_rx),
        .periph_en(periph_en), .irq_en(irq_en), .gcall_en(gcall_en),
        .sr_read(sr_read), .speed_we(speed_we), .speed_wdata(speed_wdata),
        .arb_lost(arb_lost), .bus_err(bus_err), .gen_call(gen_call), .irq(irq),
        .force_slave(force_slave), .scl_hold_inhibit(scl_hold_inhibit),
        .speed_fast(speed_fast)
    );

    typedef struct {
        string      tag;
        logic [5:0] v;   // {arb, berr, gcall, irq, inhibit, fast}
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    int   fs_cnt = 0;
    bit   finished = 0;

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            e   = exp_q.pop_front();
            act = {arb_lost, bus_err, gen_call, irq, scl_hold_inhibit, speed_fast};
            total++;
            if (act !== e.v) begin
                bad++;
                $display("FAIL %s: actual=%b expected=%b (arb,berr,gcall,irq,inh,fast)",
                         e.tag, act, e.v);
            end
        end
        if (force_slave === 1'b1) fs_cnt++;
    end

    task automatic expect_out(input string tag, input logic a, input logic b,
                              input logic g, input logic i, input logic h,
                              input logic f);
        exp_t e;
        e.tag = tag;
        e.v   = {a, b, g, i, h, f};
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic bus(input logic c, input logic d);
        @(negedge clk);
        scl_in = c;
        sda_in = d;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic want);
        sda_release = want;
        bus(1'b0, b);
        bus(1'b1, b);
        bus(1'b0, b);
    endtask

    task automatic start_c();
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
    endtask

    task automatic stop_c();
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
    endtask

    task automatic send_byte(input logic [7:0] val, input logic ack);
        for (int k = 7; k >= 0; k--) send_bit(val[k], val[k]);
        send_bit(ack, 1'b1);
    endtask

    task automatic read_pulse();
        @(negedge clk);
        sr_read = 1'b1;
        @(negedge clk);
        sr_read = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        expect_out("R9 reset state", 0, 0, 0, 0, 0, 0);

        periph_en = 1'b1;
        irq_en    = 1'b1;
        gcall_en  = 1'b1;
        @(negedge clk);
        speed_we = 1'b1; speed_wdata = 1'b1;
        @(negedge clk);
        speed_we = 1'b0;
        @(negedge clk);
        expect_out("R9 speed write", 0, 0, 0, 0, 0, 1);

        // broadcast address as slave
        start_c();
        send_byte(8'h00, 1'b0);
        expect_out("R8 gcall set", 0, 0, 1, 0, 0, 1);
        read_pulse();
        expect_out("R8 gcall kept on read", 0, 0, 1, 0, 0, 1);
        stop_c();
        expect_out("R8 gcall cleared by stop, R1 clean stop", 0, 0, 0, 0, 0, 1);

        start_c();
        send_byte(8'h10, 1'b0);
        stop_c();
        expect_out("R8 nonzero address", 0, 0, 0, 0, 0, 1);

        // misplaced stop
        start_c();
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b1);
        stop_c();
        expect_out("R1 misplaced stop, R6 irq, R7 inhibit", 0, 1, 0, 1, 1, 1);
        read_pulse();
        expect_out("R4 read clears berr", 0, 0, 0, 0, 0, 1);

        // misplaced start with interrupts masked
        irq_en = 1'b0;
        start_c();
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
        expect_out("R1 misplaced start, R6 masked irq", 0, 1, 0, 0, 1, 1);
        stop_c();
        read_pulse();
        expect_out("R4 clear after masked", 0, 0, 0, 0, 0, 1);
        irq_en = 1'b1;

        // arbitration loss
        is_master = 1'b1;
        is_rx     = 1'b0;
        start_c();
        send_bit(1'b0, 1'b1);
        expect_out("R2 arbitration lost", 1, 0, 0, 1, 1, 1);
        if (fs_cnt != 1) begin
            bad++;
            $display("FAIL R2 force_slave pulses: actual=%0d expected=1", fs_cnt);
        end
        total++;
        is_master = 1'b0;
        for (int k = 0; k < 7; k++) send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        stop_c();
        read_pulse();
        expect_out("R4 arb cleared, R1 full byte ok", 0, 0, 0, 0, 0, 1);

        // master receive: no arbitration, including ack
        is_master = 1'b1;
        is_rx     = 1'b1;
        start_c();
        for (int k = 0; k < 8; k++) send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        expect_out("R3 rx mode no arbitration", 0, 0, 0, 0, 0, 1);
        stop_c();

        // master transmit: ack bit not compared
        is_rx = 1'b0;
        start_c();
        send_byte(8'hA5, 1'b0);
        expect_out("R3 tx ack not compared", 0, 0, 0, 0, 0, 1);
        stop_c();
        is_master = 1'b0;

        // set beats read in the same cycle
        start_c();
        send_bit(1'b1, 1'b1);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        @(negedge clk);
        sda_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        sr_read = 1'b1;
        @(negedge clk);
        sr_read = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R4 set wins over read, R10 third-edge timing", 0, 1, 0, 1, 1, 1);

        // disable clears and blocks
        periph_en = 1'b0;
        repeat (2) @(negedge clk);
        expect_out("R5 disable clears, R9 speed kept", 0, 0, 0, 0, 0, 1);
        start_c();
        send_bit(1'b1, 1'b1);
        stop_c();
        expect_out("R5 no set while disabled", 0, 0, 0, 0, 0, 1);
        periph_en = 1'b1;
        repeat (2) @(negedge clk);
        expect_out("R5 re-enable stays clear", 0, 0, 0, 0, 0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule